// File: doc/BRIEF.md
# Dual-Channel Serial Frequency-Word Formatter

This block takes parallel frequency-correction words from two tracking loops, one for the carrier and one for the sample timing, and sends each word out on its own serial data line. Each line has a companion sync line. The sync line marks the bit-time just before the most significant bit goes out, so a receiver can arm its shift register one bit early. Each channel has its own load strobe and word input. A word that arrives while that channel is already sending waits in a one-deep holding register and follows straight after the current word.

Bits advance on one of two bit-rate sources, chosen by a configuration bit. The first is every system clock cycle. The second is a slow clock that the block divides from the system clock with a programmable divisor. The slow clock has a 50% duty cycle and is also driven out, so a receiver can shift on its rising edge. The active level of each sync line is set separately.

Top module: `freq_word_serializer`

## Requirements
- R1: The carrier channel and the sampler channel work independently. A word loaded on one channel appears only on that channel's data and sync pins, and the two channels may send at the same time.
- R2: Every word goes out as WORD_W bits, most significant bit first, one bit per bit-time.
- R3: The sync line is active for exactly one bit-time. The most significant bit appears in the bit-time that directly follows it.
- R4: The data pin is low whenever its channel is not presenting a word bit, including during the sync bit-time.
- R5: With `cfgUseSlow` = 0 a bit-time is one system clock cycle. With `cfgUseSlow` = 1 a bit-time is 2×(`cfgDivN`+1) system clock cycles, and in that mode `cfgDivN` has no effect on system-clock timing otherwise.
- R6: `slowClkOut` is a register that toggles every `cfgDivN`+1 system clocks, which gives a 50% duty cycle. In slow mode the data and sync lines change on the same system clock edge on which `slowClkOut` falls.
- R7: With a sync invert bit of 0 the sync line is active high. With 1 it is active low. Each channel has its own invert bit.
- R8: A word loaded while its channel is busy is sent afterwards with no gap: its sync bit-time is the bit-time right after the last bit of the previous word.
- R9: If two words arrive during one transfer, only the later one is sent after it. The earlier one is discarded.
- R10: During reset and after it, until a load arrives, both data pins are low, both sync lines are at their inactive level and `slowClkOut` starts low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfgUseSlow | input | 1 | 1 = bits advance on the divided slow clock, 0 = on every system clock |
| cfgDivN | input | DIV_W | Slow clock half period minus one, in system clocks |
| cfgSyncInvCar | input | 1 | Carrier sync line active low when 1 |
| cfgSyncInvSym | input | 1 | Sampler sync line active low when 1 |
| carLoad | input | 1 | One-cycle strobe that captures `carWord` |
| carWord | input | WORD_W | Carrier frequency-correction word |
| symLoad | input | 1 | One-cycle strobe that captures `symWord` |
| symWord | input | WORD_W | Sample-timing frequency-correction word |
| carData | output | 1 | Carrier serial data |
| carSync | output | 1 | Carrier word sync |
| symData | output | 1 | Sampler serial data |
| symSync | output | 1 | Sampler word sync |
| slowClkOut | output | 1 | Divided slow clock, 50% duty |

## Verification
A bit counter that is off by one shows on the very next word, as a word that is one bit too long or too short. When the words that follow are read back, every bit after that point is shifted. A wrong divider state or a wrong step condition shows within one slow-clock period, as a sync pulse or a bit that does not last 2×(N+1) clocks, or as a bit edge that falls on a rising slow-clock edge. A lost or stale holding-register flag shows at the end of the current word: the next sync is either missing from the bit-time after the last bit, or it carries the wrong, overwritten word.

// File: rtl/fws_pkg.sv
package fws_pkg;
  localparam int NUM_CH = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SYNC  = 2'd1,
    ST_SHIFT = 2'd2
  } chState_t;

  typedef struct packed {
    logic capPend;
    logic loadShift;
    logic shiftOne;
  } chStrobe_t;
endpackage

// File: rtl/fws_ctrl.sv
module fws_ctrl
  import fws_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DIV_W  = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   useSlow,
  input  logic [DIV_W-1:0]       divN,
  input  logic [NUM_CH-1:0]      ldStrobe,
  output chStrobe_t [NUM_CH-1:0] strobe,
  output logic [NUM_CH-1:0]      syncAct,
  output logic [NUM_CH-1:0]      shiftAct,
  output logic [NUM_CH-1:0]      pendValid,
  output logic [NUM_CH-1:0]      lastBit,
  output logic                   stepEn,
  output logic                   slowClk,
  output logic [DIV_W-1:0]       divCnt
);
  localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

  logic divWrap;

  // slow clock divider: toggles every divN+1 system clocks
  assign divWrap = (divCnt >= divN);

  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt  <= '0;
      slowClk <= 1'b0;
    end else if (divWrap) begin
      divCnt  <= '0;
      slowClk <= ~slowClk;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  // bit-time step: every clock, or on the falling edge of the slow clock
  assign stepEn = useSlow ? (divWrap && slowClk) : 1'b1;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    chState_t         state;
    logic [CNT_W-1:0] bitCnt;
    logic             pend;
    logic             isLast;
    logic             takePend;

    assign isLast   = (bitCnt == LAST_IDX);
    assign takePend = stepEn && pend &&
                      ((state == ST_IDLE) || ((state == ST_SHIFT) && isLast));

    assign strobe[c].capPend   = ldStrobe[c];
    assign strobe[c].loadShift = takePend;
    assign strobe[c].shiftOne  = stepEn && (state == ST_SHIFT) && !isLast;

    assign syncAct[c]   = (state == ST_SYNC);
    assign shiftAct[c]  = (state == ST_SHIFT);
    assign pendValid[c] = pend;
    assign lastBit[c]   = isLast;

    always_ff @(posedge clk) begin
      if (rst) begin
        pend <= 1'b0;
      end else if (ldStrobe[c]) begin
        pend <= 1'b1;
      end else if (takePend) begin
        pend <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        state  <= ST_IDLE;
        bitCnt <= '0;
      end else if (stepEn) begin
        unique case (state)
          ST_IDLE: begin
            if (pend) state <= ST_SYNC;
          end
          ST_SYNC: begin
            state  <= ST_SHIFT;
            bitCnt <= '0;
          end
          ST_SHIFT: begin
            if (isLast) begin
              state <= pend ? ST_SYNC : ST_IDLE;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/fws_datapath.sv
module fws_datapath
  import fws_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                               clk,
  input  logic                               rst,
  input  chStrobe_t [NUM_CH-1:0]             strobe,
  input  logic [NUM_CH-1:0][WORD_W-1:0]      wordIn,
  output logic [NUM_CH-1:0]                  msb
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [WORD_W-1:0] pendWord;
    logic [WORD_W-1:0] shReg;

    // holding register: a later load overwrites an unsent word
    always_ff @(posedge clk) begin
      if (rst) begin
        pendWord <= '0;
      end else if (strobe[c].capPend) begin
        pendWord <= wordIn[c];
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        shReg <= '0;
      end else if (strobe[c].loadShift) begin
        shReg <= pendWord;
      end else if (strobe[c].shiftOne) begin
        shReg <= {shReg[WORD_W-2:0], 1'b0};
      end
    end

    assign msb[c] = shReg[WORD_W-1];
  end
endmodule

// File: rtl/freq_word_serializer.sv
module freq_word_serializer
  import fws_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgUseSlow,
  input  logic [DIV_W-1:0]  cfgDivN,
  input  logic              cfgSyncInvCar,
  input  logic              cfgSyncInvSym,
  input  logic              carLoad,
  input  logic [WORD_W-1:0] carWord,
  input  logic              symLoad,
  input  logic [WORD_W-1:0] symWord,
  output logic              carData,
  output logic              carSync,
  output logic              symData,
  output logic              symSync,
  output logic              slowClkOut
);
  chStrobe_t [NUM_CH-1:0]        strobe;
  logic [NUM_CH-1:0]             syncAct;
  logic [NUM_CH-1:0]             shiftAct;
  logic [NUM_CH-1:0]             pendValid;
  logic [NUM_CH-1:0]             lastBit;
  logic [NUM_CH-1:0]             msb;
  logic [NUM_CH-1:0][WORD_W-1:0] wordIn;
  logic                          stepEn;
  logic [DIV_W-1:0]              divCnt;

  assign wordIn[0] = carWord;
  assign wordIn[1] = symWord;

  fws_ctrl #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .useSlow   (cfgUseSlow),
    .divN      (cfgDivN),
    .ldStrobe  ({symLoad, carLoad}),
    .strobe    (strobe),
    .syncAct   (syncAct),
    .shiftAct  (shiftAct),
    .pendValid (pendValid),
    .lastBit   (lastBit),
    .stepEn    (stepEn),
    .slowClk   (slowClkOut),
    .divCnt    (divCnt)
  );

  fws_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .wordIn (wordIn),
    .msb    (msb)
  );

  assign carData = shiftAct[0] & msb[0];
  assign symData = shiftAct[1] & msb[1];
  assign carSync = syncAct[0] ^ cfgSyncInvCar;
  assign symSync = syncAct[1] ^ cfgSyncInvSym;
endmodule

// File: rtl/fws_checker.sv
module fws_checker #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             useSlow,
  input logic [DIV_W-1:0] divN,
  input logic [DIV_W-1:0] divCnt,
  input logic             slowClk,
  input logic             stepEn,
  input logic [1:0]       syncAct,
  input logic [1:0]       shiftAct,
  input logic [1:0]       pendValid,
  input logic [1:0]       lastBit
);
  for (genvar c = 0; c < 2; c++) begin : g_chk
    AST_SYNC_THEN_MSB: assert property (@(posedge clk) disable iff (rst)
      (syncAct[c] && stepEn) |=> (shiftAct[c] && !syncAct[c])); // R3
    AST_SYNC_ENDS_IN_DATA: assert property (@(posedge clk) disable iff (rst)
      $fell(syncAct[c]) |-> shiftAct[c]); // R3
    AST_FAST_SYNC_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      (!useSlow && syncAct[c]) |=> !syncAct[c]); // R5
    AST_NO_GAP_AFTER_WORD: assert property (@(posedge clk) disable iff (rst)
      (shiftAct[c] && lastBit[c] && stepEn && pendValid[c]) |=> syncAct[c]); // R8
  end

  AST_SLOW_TOGGLE_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    !$stable(slowClk) |-> ($past(divCnt) >= $past(divN))); // R6
  AST_STEP_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (useSlow && stepEn) |=> !slowClk); // R6
endmodule

bind freq_word_serializer fws_checker #(.DIV_W(DIV_W)) u_fws_checker (
  .clk       (clk),
  .rst       (rst),
  .useSlow   (cfgUseSlow),
  .divN      (cfgDivN),
  .divCnt    (divCnt),
  .slowClk   (slowClkOut),
  .stepEn    (stepEn),
  .syncAct   (syncAct),
  .shiftAct  (shiftAct),
  .pendValid (pendValid),
  .lastBit   (lastBit)
);

// File: tb/freq_word_serializer_bench.sv
module freq_word_serializer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_W = 32;
  localparam int DIV_W  = 8;

  typedef struct packed {
    logic [31:0] word;
    logic        useSlow;
    logic [7:0]  divN;
    logic        inv;
    logic        ch;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{32'hA5C3_0F81, 1'b0, 8'd0, 1'b0, 1'b0},
    '{32'h8000_0001, 1'b0, 8'd0, 1'b1, 1'b1},
    '{32'h1234_5678, 1'b1, 8'd0, 1'b0, 1'b0},
    '{32'hFFFF_FFFE, 1'b1, 8'd3, 1'b1, 1'b0},
    '{32'h0000_0001, 1'b1, 8'd1, 1'b0, 1'b1},
    '{32'h7FFF_FFFF, 1'b0, 8'd5, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfgUseSlow = 1'b0;
  logic [DIV_W-1:0] cfgDivN = '0;
  logic cfgSyncInvCar = 1'b0;
  logic cfgSyncInvSym = 1'b0;
  logic carLoad = 1'b0;
  logic [WORD_W-1:0] carWord = '0;
  logic symLoad = 1'b0;
  logic [WORD_W-1:0] symWord = '0;
  logic carData, carSync, symData, symSync, slowClkOut;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  freq_word_serializer #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_freq_word_serializer (
    .clk(clk), .rst(rst), .cfgUseSlow(cfgUseSlow), .cfgDivN(cfgDivN),
    .cfgSyncInvCar(cfgSyncInvCar), .cfgSyncInvSym(cfgSyncInvSym),
    .carLoad(carLoad), .carWord(carWord), .symLoad(symLoad), .symWord(symWord),
    .carData(carData), .carSync(carSync), .symData(symData), .symSync(symSync),
    .slowClkOut(slowClkOut)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic syncActive(input int ch);
    return (ch == 0) ? (carSync ^ cfgSyncInvCar) : (symSync ^ cfgSyncInvSym);
  endfunction

  function automatic logic dataOf(input int ch);
    return (ch == 0) ? carData : symData;
  endfunction

  // called at a negedge; load is seen by the next posedge
  task automatic sendWord(input int ch, input logic [WORD_W-1:0] w);
    if (ch == 0) begin carLoad = 1'b1; carWord = w; end
    else begin symLoad = 1'b1; symWord = w; end
    @(negedge clk);
    if (ch == 0) carLoad = 1'b0; else symLoad = 1'b0;
  endtask

  // samples at the current negedge first, then walks negedges
  task automatic captureWord(input int ch, input int period,
                             output logic [WORD_W-1:0] got, output int syncLen,
                             output int dataDuringSync, output logic clkAtMsb);
    int waitCnt = 0;
    got = '0; syncLen = 0; dataDuringSync = 0;
    while (!syncActive(ch) && waitCnt < 5000) begin
      @(negedge clk);
      waitCnt++;
    end
    while (syncActive(ch) && syncLen < 5000) begin
      if (dataOf(ch)) dataDuringSync++;
      syncLen++;
      @(negedge clk);
    end
    clkAtMsb = slowClkOut;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      got[i] = dataOf(ch);
      for (int k = 0; k < period; k++) @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nErrors++;
      $display("FAIL watchdog expired (all requirements)");
      $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    logic [WORD_W-1:0] got, got2;
    int sl, dds, sl2, dds2;
    logic cam, cam2;
    int otherActivity;

    // ---- R10: reset state
    repeat (3) @(negedge clk);
    check(carData == 0 && symData == 0, "R10", "data low in reset", {carData, symData}, 0);
    check(carSync == 0 && symSync == 0, "R10", "sync inactive in reset", {carSync, symSync}, 0);
    check(slowClkOut == 0, "R10", "slow clock low in reset", slowClkOut, 0);
    rst = 1'b0;
    otherActivity = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (carData || symData || carSync || symSync) otherActivity++;
    end
    check(otherActivity == 0, "R10", "no output before first load", otherActivity, 0);

    // ---- vector table: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < NVEC; v++) begin
      int period;
      int ch;
      cfgUseSlow = VECS[v].useSlow;
      cfgDivN = VECS[v].divN;
      ch = int'(VECS[v].ch);
      cfgSyncInvCar = (ch == 0) ? VECS[v].inv : 1'b0;
      cfgSyncInvSym = (ch == 1) ? VECS[v].inv : 1'b0;
      period = VECS[v].useSlow ? 2 * (int'(VECS[v].divN) + 1) : 1;
      @(negedge clk);
      check(((ch == 0) ? carSync : symSync) == VECS[v].inv, "R7", "idle sync level",
            (ch == 0) ? carSync : symSync, VECS[v].inv);
      fork
        sendWord(ch, VECS[v].word);
        captureWord(ch, period, got, sl, dds, cam);
      join
      check(got == VECS[v].word, "R2", "word read back MSB first", got, VECS[v].word);
      check(sl == period, "R3 R5", "sync length in clocks", sl, period);
      check(dds == 0, "R4", "data low during sync", dds, 0);
      check(dataOf(ch) == 0 && !syncActive(ch), "R4", "line idle after word",
            dataOf(ch), 0);
      if (VECS[v].useSlow)
        check(cam == 0, "R6", "bits change as slow clock falls", cam, 0);
    end

    // ---- R6: slow clock duty and period
    cfgUseSlow = 1'b1;
    cfgDivN = 8'd2;
    @(negedge clk);
    while (slowClkOut) @(negedge clk);
    while (!slowClkOut) @(negedge clk);
    begin
      int hi = 0, lo = 0;
      while (slowClkOut) begin hi++; @(negedge clk); end
      while (!slowClkOut) begin lo++; @(negedge clk); end
      check(hi == 3, "R6", "slow clock high time", hi, 3);
      check(lo == 3, "R6", "slow clock low time", lo, 3);
    end

    // ---- R1: both channels at once, opposite polarities
    cfgUseSlow = 1'b0;
    cfgSyncInvCar = 1'b0;
    cfgSyncInvSym = 1'b1;
    @(negedge clk);
    fork
      sendWord(0, 32'hDEAD_BEEF);
      sendWord(1, 32'h0F0F_3C3C);
      captureWord(0, 1, got, sl, dds, cam);
      captureWord(1, 1, got2, sl2, dds2, cam2);
    join
    check(got == 32'hDEAD_BEEF, "R1", "carrier word in parallel", got, 32'hDEAD_BEEF);
    check(got2 == 32'h0F0F_3C3C, "R1", "sampler word in parallel", got2, 32'h0F0F_3C3C);
    check(sl2 == 1, "R1 R7", "active-low sampler sync length", sl2, 1);

    // ---- R1: carrier only, sampler stays quiet
    otherActivity = 0;
    fork
      sendWord(0, 32'h5555_AAAA);
      captureWord(0, 1, got, sl, dds, cam);
      for (int i = 0; i < 40; i++) begin
        if (symData || symSync != 1'b1) otherActivity++;
        @(negedge clk);
      end
    join
    check(got == 32'h5555_AAAA, "R1", "carrier word alone", got, 32'h5555_AAAA);
    check(otherActivity == 0, "R1", "sampler idle while carrier sends", otherActivity, 0);

    // ---- R8 R9: back-to-back with overwrite of the held word
    cfgSyncInvSym = 1'b0;
    @(negedge clk);
    fork
      begin
        sendWord(1, 32'hCAFE_0001);
        repeat (5) @(negedge clk);
        sendWord(1, 32'hBAD0_0002);
        repeat (3) @(negedge clk);
        sendWord(1, 32'h600D_0003);
      end
      captureWord(1, 1, got, sl, dds, cam);
    join
    check(got == 32'hCAFE_0001, "R8", "first word intact", got, 32'hCAFE_0001);
    check(syncActive(1) == 1'b1, "R8", "sync right after last bit", syncActive(1), 1);
    captureWord(1, 1, got2, sl2, dds2, cam2);
    check(got2 == 32'h600D_0003, "R9", "latest held word sent", got2, 32'h600D_0003);
    check(sl2 == 1, "R8", "sync length of follow-on word", sl2, 1);
    repeat (4) @(negedge clk);
    check(symData == 0 && symSync == 0, "R9", "no third word sent", {symData, symSync}, 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end
endmodule